// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects level-sensitive interrupt lines from up to 32 peripherals and turns them into two request lines toward a processor core: a general interrupt request and a fast interrupt request. Software enables and disables individual sources with write-one-to-act registers. It steers each source to either request line and fills a set of priority slots. Each slot binds a source number to a handler address, and a lower slot number means a higher priority.

When the core takes the general interrupt, it reads one register and gets the handler address of the highest-priority eligible source. No software search of the source is needed. That same read records the winner's priority level as in service, and the request line then ignores sources at that level or below. A later write of any value to the same register acknowledges the interrupt and restores the level that was in force before it. Handlers can therefore nest, and only a strictly higher priority can preempt the one running. Enabled general-path sources that no slot claims share a default handler address and rank below every slot.

Top module: `pvic_top`

## Requirements
- R1: After reset the enable mask, the fast/general routing, all slots, the default address and the in-service record are zero, and both `irq_o` and `fiq_o` are low.
- R2: A write to word 0x03 sets every enable bit that is 1 in the written data and leaves the others unchanged. Reads of word 0x03 or 0x04 return the current enable mask.
- R3: A write to word 0x04 clears every enable bit that is 1 in the written data and leaves the others unchanged.
- R4: Word 0x02 reads the raw source levels, whatever the enable mask holds.
- R5: Word 0x00 reads raw & enable & ~route, the pending general sources. Word 0x01 reads raw & enable & route, the pending fast sources. Word 0x05 is the routing register, where 1 means fast.
- R6: `fiq_o` is high exactly when a pending fast source exists, and the in-service record does not affect it.
- R7: `irq_o` is high exactly when an eligible general source exists. A source is eligible when it is assigned to an enabled slot whose number is below the current ceiling, or when it is unassigned and the ceiling is above the default level.
- R8: Slot k has its handler address at word 0x10+k and its control at word 0x20+k (bit 5 enable, bits 4:0 source number). A read of word 0x06 returns the handler address of the lowest-numbered eligible slot. If several slots name the same source, the lowest slot wins.
- R9: Unassigned pending general sources rank at default level 16, below every slot. A read of word 0x06 with one of them as the winner returns the default address held in word 0x07.
- R10: A read of word 0x06 with an eligible winner lowers the ceiling to the winner's level. Until the acknowledge, sources at that level or below do not raise `irq_o`, and sources at a higher priority do.
- R11: A write of any value to word 0x06 removes the most recently recorded (highest-priority) level, so the ceiling returns to the previous one. The write has no effect when nothing is in service.
- R12: A read of word 0x06 with no eligible source returns the default address and records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while `bus_rd` is high |
| src_i | input | 32 | Level-sensitive source lines, active high |
| irq_o | output | 1 | General interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
The assertions assume that a read and a write never occur in the same cycle. They also assume that the source lines change only in step with the clock, because the block samples them with no synchronizer. The bench drives every access and every source change on the falling edge and keeps each strobe high for exactly one cycle. It samples the request lines and the read data one time unit later. It never raises both strobes together, and it acknowledges only after a read that recorded a level, except in the one case that checks an acknowledge with nothing in service.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int ADDR_W = 8;

  // Word addresses of the register map
  localparam logic [ADDR_W-1:0] A_IRQ_ST = 8'h00;
  localparam logic [ADDR_W-1:0] A_FIQ_ST = 8'h01;
  localparam logic [ADDR_W-1:0] A_RAW    = 8'h02;
  localparam logic [ADDR_W-1:0] A_EN_SET = 8'h03;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 8'h04;
  localparam logic [ADDR_W-1:0] A_ROUTE  = 8'h05;
  localparam logic [ADDR_W-1:0] A_VECT   = 8'h06;
  localparam logic [ADDR_W-1:0] A_DEF    = 8'h07;

  // Upper nibble pages for per-slot registers; low nibble is the slot index
  localparam logic [3:0] PG_SLOT_ADDR = 4'h1;
  localparam logic [3:0] PG_SLOT_CTRL = 4'h2;
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  input  logic [NUM_SRC-1:0]                  raw,
  input  logic [DATA_W-1:0]                   vect_data,
  output logic [DATA_W-1:0]                   rdata,
  output logic [NUM_SRC-1:0]                  en,
  output logic [NUM_SRC-1:0]                  route,
  output logic [DATA_W-1:0]                   def_addr,
  output logic [NUM_SLOTS-1:0]                slot_en,
  output logic [NUM_SLOTS-1:0][SRC_W-1:0]     slot_src,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]    slot_addr
);
  logic               wr_set, wr_clr, wr_route, wr_def, en_we;
  logic [NUM_SRC-1:0] en_nxt;

  assign wr_set   = wr && (addr == A_EN_SET);
  assign wr_clr   = wr && (addr == A_EN_CLR);
  assign wr_route = wr && (addr == A_ROUTE);
  assign wr_def   = wr && (addr == A_DEF);
  assign en_we    = wr_set || wr_clr;

  always_comb begin
    en_nxt = en;
    if (wr_set) en_nxt = en_nxt | wdata[NUM_SRC-1:0];
    if (wr_clr) en_nxt = en_nxt & ~wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      route    <= '0;
      def_addr <= '0;
    end else begin
      if (en_we)    en       <= en_nxt;
      if (wr_route) route    <= wdata[NUM_SRC-1:0];
      if (wr_def)   def_addr <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic we_addr, we_ctrl;
    assign we_addr = wr && (addr == {PG_SLOT_ADDR, 4'(g)});
    assign we_ctrl = wr && (addr == {PG_SLOT_CTRL, 4'(g)});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[g] <= '0;
        slot_en[g]   <= 1'b0;
        slot_src[g]  <= '0;
      end else begin
        if (we_addr) slot_addr[g] <= wdata;
        if (we_ctrl) begin
          slot_en[g]  <= wdata[SRC_W];
          slot_src[g] <= wdata[SRC_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_IRQ_ST:           rdata[NUM_SRC-1:0] = raw & en & ~route;
      A_FIQ_ST:           rdata[NUM_SRC-1:0] = raw & en & route;
      A_RAW:              rdata[NUM_SRC-1:0] = raw;
      A_EN_SET, A_EN_CLR: rdata[NUM_SRC-1:0] = en;
      A_ROUTE:            rdata[NUM_SRC-1:0] = route;
      A_VECT:             rdata = vect_data;
      A_DEF:              rdata = def_addr;
      default: begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (addr == {PG_SLOT_ADDR, 4'(i)}) rdata = slot_addr[i];
          if (addr == {PG_SLOT_CTRL, 4'(i)}) rdata[SRC_W:0] = {slot_en[i], slot_src[i]};
        end
      end
    endcase
  end

  // R2: every bit written to the set word is enabled on the next cycle
  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set && !wr_clr |=> ((en & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));
  // R3: every bit written to the clear word is disabled on the next cycle
  p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en & $past(wdata[NUM_SRC-1:0])) == '0));
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int LVL_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic [NUM_SRC-1:0]              irq_pend,
  input  logic [NUM_SLOTS-1:0]            slot_en,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src,
  input  logic [LVL_W-1:0]                ceiling,
  output logic                            win_valid,
  output logic [LVL_W-1:0]                win_lvl
);
  logic [NUM_SRC-1:0]   covered;
  logic [NUM_SLOTS-1:0] hit;
  logic                 dflt_hit;

  always_comb begin
    covered = '0;
    hit     = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_en[i]) covered[slot_src[i]] = 1'b1;
      hit[i] = slot_en[i] && irq_pend[slot_src[i]] && (LVL_W'(i) < ceiling);
    end
  end

  assign dflt_hit = (|(irq_pend & ~covered)) && (LVL_W'(NUM_SLOTS) < ceiling);

  // Walk from the lowest priority upward; the last hit is the highest priority
  always_comb begin
    win_valid = 1'b0;
    win_lvl   = LVL_W'(NUM_SLOTS);
    if (dflt_hit) win_valid = 1'b1;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_valid = 1'b1;
        win_lvl   = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/pvic_inservice.sv
module pvic_inservice #(
  parameter int NUM_LVL = 17,
  localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] ceiling
);
  logic [NUM_LVL-1:0] busy, busy_nxt;
  logic               upd;

  always_comb begin
    ceiling = LVL_W'(NUM_LVL);
    for (int i = NUM_LVL - 1; i >= 0; i--)
      if (busy[i]) ceiling = LVL_W'(i);
  end

  assign upd = push || pop;

  always_comb begin
    busy_nxt = busy;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (pop && (ceiling == LVL_W'(i)))  busy_nxt[i] = 1'b0;
      if (push && (push_lvl == LVL_W'(i))) busy_nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   busy <= '0;
    else if (upd) busy <= busy_nxt;
  end

  // R10: only a strictly higher priority than the current ceiling is recorded
  p_push_above_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_lvl < ceiling));
  // R10: the recorded level becomes the new ceiling
  p_push_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> (ceiling == $past(push_lvl)));
  // R11: an acknowledge removes exactly one recorded level
  p_pop_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && (busy != '0) |=> ($countones(busy) == $countones($past(busy)) - 1));
  // R11: an acknowledge with nothing recorded changes nothing
  p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && (busy == '0) |=> (busy == '0));
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0]  src_i,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int NUM_LVL = NUM_SLOTS + 1;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);

  logic [NUM_SRC-1:0]              en, route, irq_pend;
  logic [DATA_W-1:0]               def_addr, vect_data;
  logic [NUM_SLOTS-1:0]            slot_en;
  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_addr;
  logic                            win_valid, push, pop;
  logic [LVL_W-1:0]                win_lvl, ceiling;

  pvic_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_regs (
    .clk, .rst_n, .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .raw(src_i),
    .vect_data, .rdata(bus_rdata), .en, .route, .def_addr, .slot_en, .slot_src, .slot_addr
  );

  assign irq_pend = src_i & en & ~route;
  assign fiq_o    = |(src_i & en & route);

  pvic_arbiter #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_arb (
    .irq_pend, .slot_en, .slot_src, .ceiling, .win_valid, .win_lvl
  );

  assign irq_o = win_valid;
  assign push  = bus_rd && (bus_addr == A_VECT) && win_valid;
  assign pop   = bus_wr && (bus_addr == A_VECT);

  pvic_inservice #(.NUM_LVL(NUM_LVL)) u_isv (
    .clk, .rst_n, .push, .push_lvl(win_lvl), .pop, .ceiling
  );

  always_comb begin
    vect_data = def_addr;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (win_valid && (win_lvl == LVL_W'(i))) vect_data = slot_addr[i];
  end

  // R11: read and write strobes never share a cycle
  p_single_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  // R7: a general request needs some enabled, general-routed source
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_pend != '0));
  // R9: a default-level winner can only exist while the default address is returned
  p_def_vect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && (win_lvl == LVL_W'(NUM_SLOTS)) |-> (vect_data == def_addr));
endmodule

// File: tb/sim_pvic_top.sv
module sim_pvic_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 15;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] raw;
    logic        irq;
    logic        fiq;
    logic [3:0]  req;
  } vec_t;

  // wr, addr, data (write data or expected read), raw, irq, fiq, requirement
  localparam vec_t TBL [N_VEC] = '{
    '{1'b0, 8'h03, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'd1},  // R1 enable reset
    '{1'b1, 8'h03, 32'h0000_00F0, 32'h0000_0000, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 8'h04, 32'h0000_00F0, 32'h0000_0000, 1'b0, 1'b0, 4'd2},  // R2 read via clear word
    '{1'b1, 8'h03, 32'h0000_0103, 32'h0000_0000, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 8'h03, 32'h0000_01F3, 32'h0000_0000, 1'b0, 1'b0, 4'd2},  // R2 OR-in
    '{1'b1, 8'h04, 32'h0000_0030, 32'h0000_0000, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b0, 8'h03, 32'h0000_01C3, 32'h0000_0000, 1'b0, 1'b0, 4'd3},  // R3 only bits cleared
    '{1'b0, 8'h02, 32'hA5A5_0011, 32'hA5A5_0011, 1'b1, 1'b0, 4'd4},  // R4 raw ignores mask
    '{1'b1, 8'h05, 32'h0000_0101, 32'h0000_0101, 1'b0, 1'b1, 4'd6},  // R6 routed to fast
    '{1'b0, 8'h00, 32'h0000_00C2, 32'h0000_01C3, 1'b1, 1'b1, 4'd5},  // R5 general status
    '{1'b0, 8'h01, 32'h0000_0101, 32'h0000_01C3, 1'b1, 1'b1, 4'd5},  // R5 fast status
    '{1'b0, 8'h05, 32'h0000_0101, 32'h0000_01C3, 1'b1, 1'b1, 4'd5},  // R5 route readback
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0000_01C3, 1'b0, 1'b0, 4'd3},  // R3 clear all
    '{1'b0, 8'h00, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'd5},  // R5 nothing enabled
    '{1'b1, 8'h05, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'd7}   // R7 idle
  };

  localparam logic [31:0] DEF_A  = 32'hDEAD_0000;
  localparam logic [31:0] SLOT2  = 32'h4000_0020;
  localparam logic [31:0] SLOT5  = 32'h4000_0050;
  localparam logic [31:0] SLOT9  = 32'h4000_0090;

  logic        clk, rst_n, bus_rd, bus_wr, irq_o, fiq_o;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, src_i;
  int          n_chk, n_fail;
  logic        done;

  pvic_top u0 (
    .clk, .rst_n, .bus_rd, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .src_i, .irq_o, .fiq_o
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic src(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    #1;
  endtask

  task automatic ack();
    wr(8'h06, 32'h1234_5678);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    done = 1'b0; n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    chk("R1 irq_o", 32'(irq_o), 32'd0);
    chk("R1 fiq_o", 32'(fiq_o), 32'd0);
    rd(8'h06, d); chk("R1 vector default", d, 32'h0);
    rd(8'h05, d); chk("R1 route", d, 32'h0);

    // Table walk
    for (int i = 0; i < N_VEC; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", TBL[i].req, i);
      if (TBL[i].wr) begin
        src(TBL[i].raw);
        wr(TBL[i].addr, TBL[i].data);
        chk({tag, " irq"}, 32'(irq_o), 32'(TBL[i].irq));
        chk({tag, " fiq"}, 32'(fiq_o), 32'(TBL[i].fiq));
      end else begin
        src(TBL[i].raw);
        chk({tag, " irq"}, 32'(irq_o), 32'(TBL[i].irq));
        chk({tag, " fiq"}, 32'(fiq_o), 32'(TBL[i].fiq));
        rd(TBL[i].addr, d);
        chk({tag, " rdata"}, d, TBL[i].data);
      end
    end

    // Slot setup: slot2 src6, slot5 src9, slot9 src12, slot12 src6
    wr(8'h07, DEF_A);
    wr(8'h12, SLOT2); wr(8'h22, 32'h26);
    wr(8'h15, SLOT5); wr(8'h25, 32'h29);
    wr(8'h19, SLOT9); wr(8'h29, 32'h2C);
    wr(8'h1C, 32'h4000_00C0); wr(8'h2C, 32'h26);
    wr(8'h03, 32'h0010_1240);
    rd(8'h29, d); chk("R8 slot control readback", d, 32'h2C);
    rd(8'h07, d); chk("R9 default readback", d, DEF_A);

    // Nesting and preemption
    src(32'h0000_0200);
    chk("R7 irq with slot source", 32'(irq_o), 32'd1);
    rd(8'h06, d); chk("R8 vector slot5", d, SLOT5);
    chk("R10 same level masked", 32'(irq_o), 32'd0);
    src(32'h0000_1200);
    chk("R10 lower level masked", 32'(irq_o), 32'd0);
    src(32'h0000_1240);
    chk("R10 higher level preempts", 32'(irq_o), 32'd1);
    rd(8'h06, d); chk("R8 vector slot2", d, SLOT2);
    chk("R10 nested masked", 32'(irq_o), 32'd0);
    ack();
    chk("R11 ceiling back to slot5", 32'(irq_o), 32'd1);
    src(32'h0000_1200);
    chk("R11 slot5 still in service", 32'(irq_o), 32'd0);
    ack();
    chk("R11 all released", 32'(irq_o), 32'd1);
    rd(8'h06, d); chk("R8 slot5 beats slot9", d, SLOT5);
    ack();
    src(32'h0000_1000);
    rd(8'h06, d); chk("R8 vector slot9", d, SLOT9);
    ack();
    src(32'h0000_0040);
    rd(8'h06, d); chk("R8 duplicate source lowest slot", d, SLOT2);
    ack();

    // Read with nothing eligible
    src(32'h0);
    chk("R12 idle irq", 32'(irq_o), 32'd0);
    rd(8'h06, d); chk("R12 idle vector", d, DEF_A);
    src(32'h0000_0200);
    rd(8'h06, d); chk("R12 slot5 taken", d, SLOT5);
    src(32'h0);
    rd(8'h06, d); chk("R12 masked read gives default", d, DEF_A);
    ack();
    src(32'h0000_1000);
    chk("R12 one ack suffices", 32'(irq_o), 32'd1);

    // Unassigned sources at default level
    src(32'h0010_0000);
    chk("R9 unassigned raises irq", 32'(irq_o), 32'd1);
    rd(8'h06, d); chk("R9 default vector", d, DEF_A);
    chk("R9 default level masked", 32'(irq_o), 32'd0);
    src(32'h0010_1000);
    chk("R9 slot above default", 32'(irq_o), 32'd1);
    rd(8'h06, d); chk("R9 preempting slot9", d, SLOT9);
    ack(); ack();
    rd(8'h06, d); chk("R9 slot beats default", d, SLOT9);
    ack();

    // Acknowledge with nothing in service
    src(32'h0);
    ack();
    src(32'h0000_0200);
    rd(8'h06, d); chk("R11 empty ack harmless", d, SLOT5);
    chk("R11 slot5 recorded", 32'(irq_o), 32'd0);
    ack();

    // Fast path ignores in-service masking
    src(32'h0000_0040);
    rd(8'h06, d); chk("R6 slot2 taken", d, SLOT2);
    wr(8'h05, 32'h0000_1000);
    src(32'h0000_1040);
    chk("R6 fiq while masked", 32'(fiq_o), 32'd1);
    chk("R6 irq still masked", 32'(irq_o), 32'd0);
    ack();
    wr(8'h05, 32'h0);
    src(32'h0);
    chk("R6 fiq low", 32'(fiq_o), 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule